// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block gives software a single byte-wide control register through which it can reach a 1-bit serial EEPROM. The EEPROM pins are shared with a memory port. Software writes the request bit. The block then waits until the memory port reports that it is idle, takes the port, and raises a ready flag.

Once the port is owned, three register bits drive chip select, serial clock and data-out straight onto the EEPROM pins. The EEPROM's data output is synchronised and read back in the lowest register bit. Every later write that keeps the request set drops ready. Ready comes back only after a fixed settle time, which lets software pace a bit-banged serial protocol without a timer of its own. The first rise of ready is different: it marks the grant and has no fixed delay. Writing the request bit as zero gives the port back.

The settle time is set in nanoseconds and converted to clock cycles from the clock period parameter. Defaults are 800 ns at 10 ns, which gives 80 cycles. Data-in passes through a synchroniser of `SYNC_STAGES` flops, 2 by default.

Top module: `ee_port_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and all three EEPROM output pins are low.
- R2: A write with bit 5 (request) set while `mem_busy_i` is low makes bit 7 (granted) and bit 4 (ready) read 1 from the second clock edge after the write. Ready never reads 1 without the grant.
- R3: While the request is pending and the memory port stays busy, bits 7 and 4 read 0 and the three pins stay low, whatever bits 3..1 hold. Bits 6 and 5 read 1 (request outstanding).
- R4: While granted, a write with the request set drives bit 3 to `ee_cs_o`, bit 2 to `ee_sk_o` and bit 1 to `ee_do_o` from the write's clock edge. Those bits read back at the same positions.
- R5: While granted, a write with the request set clears ready at its edge. Ready reads 0 for exactly `DELAY_CYC` edges and reads 1 from the `DELAY_CYC`-th edge after the write.
- R6: A further write during the settle window restarts it. Ready rises `DELAY_CYC` edges after the last write.
- R7: While granted, bit 0 reads the `ee_di_i` level sampled `SYNC_STAGES` edges earlier. While not granted, bit 0 reads 0.
- R8: A write with bit 5 clear releases the port at its edge: bits 7, 6, 5, 4 and 3..1 read 0 and the pins go low. A later request must win arbitration again.
- R9: Once granted, ownership holds while `mem_busy_i` rises, until software releases it.
- R10: Bits 7, 6, 4 and 0 are read-only. Writing them has no effect on the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| mem_busy_i | input | 1 | Shared memory port busy with another request |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_do_o | output | 1 | Data toward the EEPROM |
| ee_di_i | input | 1 | Data from the EEPROM |

## Verification
Each result is due at a known edge count after its stimulus:
- Pin levels and the register bits written by software are due one edge after the write.
- The grant and the first ready are due one edge after the memory port is seen idle, which is two edges after the request write.
- Ready after a paced write is due exactly `DELAY_CYC` edges after the write.
- Data-in is due `SYNC_STAGES` edges after the pin changes.

The driver records each expectation with the absolute cycle at which it falls due. The monitor compares the outputs only at the falling edge of that cycle. It flags any expectation that was left unchecked. Pairs of checks one cycle before and at the due edge pin down the exact edge where ready rises.

// File: rtl/ee_port_pkg.sv
package ee_port_pkg;
  localparam int unsigned B_ACK  = 7;
  localparam int unsigned B_PEND = 6;
  localparam int unsigned B_REQ  = 5;
  localparam int unsigned B_RDY  = 4;
  localparam int unsigned B_CS   = 3;
  localparam int unsigned B_SK   = 2;
  localparam int unsigned B_DO   = 1;
  localparam int unsigned B_DI   = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;

  typedef struct packed {
    logic cs;
    logic sk;
    logic dout;
  } pin_bits_t;
endpackage

// File: rtl/ee_arb.sv
module ee_arb
  import ee_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       req_bit_i,
  input  logic       busy_i,
  output arb_state_e state_o
);
  arb_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_i && !req_bit_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (wr_i && req_bit_i) st_d = ST_WAIT;
        ST_WAIT: if (!busy_i) st_d = ST_OWN;
        ST_OWN:  st_d = ST_OWN;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/ee_pace_timer.sv
module ee_pace_timer #(
  parameter int unsigned DELAY_CYC = 80,
  localparam int unsigned CW = $clog2(DELAY_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic idle_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(DELAY_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/ee_din_sync.sv
module ee_din_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ee_port_ctrl.sv
module ee_port_ctrl
  import ee_port_pkg::*;
#(
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned SETTLE_NS   = 800,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DELAY_RAW  = (SETTLE_NS + CLK_NS - 1) / CLK_NS,
  localparam int unsigned DELAY_CYC  = (DELAY_RAW == 0) ? 1 : DELAY_RAW
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       mem_busy_i,
  output logic       ee_cs_o,
  output logic       ee_sk_o,
  output logic       ee_do_o,
  input  logic       ee_di_i
);
  arb_state_e st;
  pin_bits_t  pins_q;
  logic       owned, pending, req_wr, rel_wr, timer_idle, din_s;

  assign req_wr = reg_wr_i &&  reg_wdata_i[B_REQ];
  assign rel_wr = reg_wr_i && !reg_wdata_i[B_REQ];

  ee_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .req_bit_i (reg_wdata_i[B_REQ]),
    .busy_i    (mem_busy_i),
    .state_o   (st)
  );

  assign owned   = (st == ST_OWN);
  assign pending = (st != ST_IDLE);

  ee_pace_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (req_wr && owned),
    .clear_i (rel_wr),
    .idle_o  (timer_idle)
  );

  ee_din_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (owned & ee_di_i),
    .q_o    (din_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_wdata_i[B_REQ]) begin
        pins_q.cs   <= reg_wdata_i[B_CS];
        pins_q.sk   <= reg_wdata_i[B_SK];
        pins_q.dout <= reg_wdata_i[B_DO];
      end else begin
        pins_q <= '0;
      end
    end
  end

  // pins stay low until the memory port is ours
  assign ee_cs_o = owned & pins_q.cs;
  assign ee_sk_o = owned & pins_q.sk;
  assign ee_do_o = owned & pins_q.dout;

  always_comb begin
    reg_rdata_o         = '0;
    reg_rdata_o[B_ACK]  = owned;
    reg_rdata_o[B_PEND] = pending;
    reg_rdata_o[B_REQ]  = pending;
    reg_rdata_o[B_RDY]  = owned & timer_idle;
    reg_rdata_o[B_CS]   = pins_q.cs;
    reg_rdata_o[B_SK]   = pins_q.sk;
    reg_rdata_o[B_DO]   = pins_q.dout;
    reg_rdata_o[B_DI]   = owned & din_s;
  end
endmodule

// File: rtl/ee_port_ctrl_chk.sv
module ee_port_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       mem_busy_i,
  input logic       ee_cs_o,
  input logic       ee_sk_o,
  input logic       ee_do_o
);
  AST_PINS_LOW_UNGRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[7] |-> !(ee_cs_o || ee_sk_o || ee_do_o)); // R3

  AST_READY_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[4] |-> reg_rdata_o[7]); // R2

  AST_GRANT_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[7]) |-> $past(!mem_busy_i)); // R2

  AST_WRITE_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[5] && reg_rdata_o[7]) |=> !reg_rdata_o[4]); // R5

  AST_PINS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[5] && reg_rdata_o[7]) |=>
      ({ee_cs_o, ee_sk_o, ee_do_o} == $past(reg_wdata_i[3:1]))); // R4

  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !reg_wdata_i[5]) |=> (reg_rdata_o[7:1] == 7'd0)); // R8

  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[7] && !(reg_wr_i && !reg_wdata_i[5])) |=> reg_rdata_o[7]); // R9
endmodule

bind ee_port_ctrl ee_port_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mem_busy_i  (mem_busy_i),
  .ee_cs_o     (ee_cs_o),
  .ee_sk_o     (ee_sk_o),
  .ee_do_o     (ee_do_o)
);

// File: tb/ee_port_ctrl_bench.sv
module ee_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D          = 80;   // 800 ns / 10 ns
  localparam int WDOG       = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       mem_busy_i = 1'b1;
  logic       ee_cs_o, ee_sk_o, ee_do_o;
  logic       ee_di_i = 1'b0;

  ee_port_ctrl u_ee_port_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .mem_busy_i  (mem_busy_i),
    .ee_cs_o     (ee_cs_o),
    .ee_sk_o     (ee_sk_o),
    .ee_do_o     (ee_do_o),
    .ee_di_i     (ee_di_i)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  typedef struct {
    int         due;
    logic [7:0] rd;
    logic [2:0] pins;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // driver side: expectation due dly cycles from now
  task automatic expect_at(int dly, logic [7:0] rd, logic [2:0] pins, string tag);
    exp_t e;
    e.due = cyc + dly; e.rd = rd; e.pins = pins; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr_reg(logic [7:0] d);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // monitor: compare every expectation at its due cycle
  always @(negedge clk_i) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].due <= cyc) begin
        checks++;
        if (exp_q[i].due < cyc) begin
          failures++;
          $display("FAIL %s missed due cycle %0d (now %0d)", exp_q[i].tag, exp_q[i].due, cyc);
        end else if (reg_rdata_o !== exp_q[i].rd ||
                     {ee_cs_o, ee_sk_o, ee_do_o} !== exp_q[i].pins) begin
          failures++;
          $display("FAIL %s cyc=%0d rdata=%02h pins=%03b expected rdata=%02h pins=%03b",
                   exp_q[i].tag, cyc, reg_rdata_o, {ee_cs_o, ee_sk_o, ee_do_o},
                   exp_q[i].rd, exp_q[i].pins);
        end
        exp_q.delete(i);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WDOG);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(2);
    expect_at(0, 8'h00, 3'b000, "R1 reset");
    idle(1);
    rst_ni = 1'b1;
    idle(1);
    expect_at(0, 8'h00, 3'b000, "R1 after reset");

    // request while memory port busy
    ee_di_i = 1'b1;
    wr_reg(8'h2E);
    expect_at(0, 8'h6E, 3'b000, "R3 pending");
    expect_at(4, 8'h6E, 3'b000, "R3 still pending, R7 din masked");
    idle(5);

    // port goes idle: grant
    mem_busy_i = 1'b0;
    expect_at(1, 8'hFE, 3'b111, "R2 grant");
    expect_at(3, 8'hFF, 3'b111, "R7 din high");
    idle(4);

    mem_busy_i = 1'b1;
    expect_at(3, 8'hFF, 3'b111, "R9 hold grant");
    idle(4);

    // paced write
    wr_reg(8'h24);
    expect_at(0, 8'hE5, 3'b010, "R4 pins");
    expect_at(D - 1, 8'hE5, 3'b010, "R5 ready low");
    expect_at(D, 8'hF5, 3'b010, "R5 ready rises");
    idle(D + 2);

    // restart
    wr_reg(8'h28);
    expect_at(0, 8'hE9, 3'b100, "R6 first write");
    idle(9);
    wr_reg(8'h2A);
    expect_at(D - 1, 8'hEB, 3'b101, "R6 restarted low");
    expect_at(D, 8'hFB, 3'b101, "R6 restarted rise");
    idle(D + 2);

    ee_di_i = 1'b0;
    expect_at(1, 8'hFB, 3'b101, "R7 din sync delay");
    expect_at(2, 8'hFA, 3'b101, "R7 din low");
    idle(3);

    // release
    wr_reg(8'h0E);
    expect_at(0, 8'h00, 3'b000, "R8 release");
    expect_at(5, 8'h00, 3'b000, "R8 stays released");
    idle(6);

    // re-arbitrate
    wr_reg(8'h20);
    expect_at(0, 8'h60, 3'b000, "R8 re-request waits");
    idle(3);
    mem_busy_i = 1'b0;
    expect_at(1, 8'hF0, 3'b000, "R2 regrant");
    idle(2);

    // read-only bits ignored
    wr_reg(8'hF1);
    expect_at(0, 8'hE0, 3'b000, "R10 ro bits ignored");
    expect_at(D, 8'hF0, 3'b000, "R10 ready returns");
    idle(D + 2);

    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL leftover expectations %0d", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule